// File: doc/BRIEF.md
# Shadow-Buffered Audio PWM Generator

This block produces a single pulse-width-modulated output for audio playback, one 8-bit sample per frame. A free-running counter counts from zero up to a programmed frame length and then restarts. The output stays inactive at the start of each frame. It turns active in the cycle where the counter equals the duty compare value, and it stays active until the frame ends.

Software never writes the live compare or frame-length values. Each write lands in a shadow register. Both shadows are copied into the live registers together at the frame boundary, so a duty change made at any moment cannot drop or split a pulse. A sticky boundary flag, which can be routed to an interrupt line, lets software pace its sample writes to the frames.

The frame sequencer has three states. `ST_QUIET` is the first frame after reset, during which the output is held inactive. `ST_WAIT` is the part of a frame before the compare hit. `ST_ACTIVE` is the part after the hit. The transitions are as follows:
- QUIET→WAIT on the frame end.
- WAIT→ACTIVE on a compare hit that is not in the frame's last cycle.
- WAIT→WAIT on the frame end.
- ACTIVE→WAIT on the frame end.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset the counter and both compare registers are zero, the frame-length registers hold RST_PERIOD, `upd_pending` and `irq` are 0, and `pwm_out` stays inactive (0) for the whole first frame.
- R2: A frame lasts (live period + 1) cycles, with the counter running from 0 to the live period. `frame_evt` is a one-cycle pulse in the frame's last cycle, and the counter is 0 in the following cycle.
- R3: Within a frame, `pwm_out` is 0 from the start until the counter equals the live compare value. It is 1 from that cycle to the end of the frame, so it is high for (period + 1 − compare) cycles.
- R4: A compare value of 0 keeps `pwm_out` high for the entire frame. A compare value greater than the period keeps it low for the entire frame.
- R5: A write to address 0 loads the duty shadow. The live compare value is updated only at the frame end, so a frame that is in progress finishes with its old compare value.
- R6: If several duty writes occur within one frame, the last one is the value that gets committed.
- R7: A write to address 1 loads the period shadow. It is committed at the same frame end as the duty value, so the frame in progress keeps its length.
- R8: `upd_pending` becomes 1 after a write to address 0 or 1 and returns to 0 after the frame-end commit. A write made in the frame-end cycle itself leaves it at 1.
- R9: The boundary flag is set at every frame end and stays set (sticky). `irq` equals the flag AND the enable bit. A write to address 2 loads the enable bit from data bit 0, and data bit 1 = 1 clears the flag. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 duty, 1 period, 2 control |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | 1 | PWM output, where 1 is the active level |
| frame_evt | output | 1 | One-cycle pulse in the last cycle of a frame |
| irq | output | 1 | Boundary interrupt (flag AND enable) |
| upd_pending | output | 1 | Shadow values are waiting to be committed |

## Verification
The bench builds the block with DATA_W = 8 and RST_PERIOD = 15. The short reset frame makes the quiet first frame and several short frames cheap to measure. The 8-bit width still allows a full 256-cycle frame, so the mid-frame case can be run exactly: compare 190 is live, 90 is written with the counter near 150, and the bench checks that this frame keeps 66 high cycles before the next frame switches to 166. The bench also programs short periods, which makes the edge values reachable: compare 0, compare equal to the period, compare above the period, and a period write that lands in the frame-end cycle.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_DUTY = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } pwm_state_e;

endpackage

// File: rtl/dbuf_pwm_regs.sv
module dbuf_pwm_regs
    import dbuf_pwm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_PERIOD = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output logic [DATA_W-1:0] duty_act,
    output logic [DATA_W-1:0] per_act,
    output logic              pending,
    output logic              irq_flag,
    output logic              irq_en
);

    localparam logic [DATA_W-1:0] PER_INIT = DATA_W'(RST_PERIOD);

    logic [DATA_W-1:0] duty_sh;
    logic [DATA_W-1:0] per_sh;
    logic wr_duty, wr_per, wr_ctrl, clr_req;

    assign wr_duty = wr_en && (wr_addr == ADDR_DUTY);
    assign wr_per  = wr_en && (wr_addr == ADDR_PER);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign clr_req = wr_ctrl && wr_data[CTRL_CLR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_sh  <= '0;
            duty_act <= '0;
            per_sh   <= PER_INIT;
            per_act  <= PER_INIT;
            pending  <= 1'b0;
            irq_flag <= 1'b0;
            irq_en   <= 1'b0;
        end else begin
            if (wr_duty) duty_sh <= wr_data;
            if (wr_per)  per_sh  <= wr_data;
            if (frame_end) begin
                duty_act <= duty_sh;
                per_act  <= per_sh;
            end
            if (wr_duty || wr_per) pending <= 1'b1;
            else if (frame_end)    pending <= 1'b0;
            if (wr_ctrl) irq_en <= wr_data[CTRL_EN_BIT];
            if (frame_end)    irq_flag <= 1'b1;
            else if (clr_req) irq_flag <= 1'b0;
        end
    end

    // R5
    commit_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> duty_act == $past(duty_sh));

    // R5
    hold_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(duty_act));

    // R7
    hold_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(per_act));

    // R8
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !wr_duty && !wr_per) |=> !pending);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_req) |=> irq_flag);

endmodule

// File: rtl/dbuf_pwm_core.sv
module dbuf_pwm_core
    import dbuf_pwm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] per_act,
    input  logic [DATA_W-1:0] duty_act,
    output logic              frame_end,
    output logic              pwm_out
);

    logic [DATA_W-1:0] cnt_q;
    logic              hit;
    pwm_state_e        state_q, state_d;

    assign frame_end = (cnt_q == per_act);
    assign hit       = (cnt_q == duty_act);

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (frame_end) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (frame_end) state_d = ST_WAIT;
            ST_WAIT:   if (!frame_end && hit) state_d = ST_ACTIVE;
            ST_ACTIVE: if (frame_end) state_d = ST_WAIT;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        pwm_out = 1'b0;
        unique case (state_q)
            ST_QUIET:  pwm_out = 1'b0;
            ST_WAIT:   pwm_out = hit;
            ST_ACTIVE: pwm_out = 1'b1;
            default:   pwm_out = 1'b0;
        endcase
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> cnt_q == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> cnt_q == $past(cnt_q) + 1'b1);

    // R1
    quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_QUIET |-> !pwm_out);

    // R3
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out && !frame_end) |=> pwm_out);

endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm
    import dbuf_pwm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RST_PERIOD = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              frame_evt,
    output logic              irq,
    output logic              upd_pending
);

    logic [DATA_W-1:0] duty_act;
    logic [DATA_W-1:0] per_act;
    logic              frame_end;
    logic              irq_flag;
    logic              irq_en;

    dbuf_pwm_regs #(
        .DATA_W     (DATA_W),
        .RST_PERIOD (RST_PERIOD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .duty_act  (duty_act),
        .per_act   (per_act),
        .pending   (upd_pending),
        .irq_flag  (irq_flag),
        .irq_en    (irq_en)
    );

    dbuf_pwm_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .per_act   (per_act),
        .duty_act  (duty_act),
        .frame_end (frame_end),
        .pwm_out   (pwm_out)
    );

    assign frame_evt = frame_end;
    assign irq       = irq_flag && irq_en;

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && irq_flag));

endmodule

// File: tb/dbuf_pwm_tb.sv
module dbuf_pwm_tb;

    localparam int DATA_W = 8;
    localparam int RST_P  = 15;
    localparam int WDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic pwm_out, frame_evt, irq, upd_pending;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    dbuf_pwm #(.DATA_W(DATA_W), .RST_PERIOD(RST_P)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .frame_evt(frame_evt),
        .irq(irq), .upd_pending(upd_pending)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_bad++;
            $display("FAIL watchdog: run exceeded %0d cycles", WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one-cycle register write, starting and ending at a negedge
    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_frame();
        do @(negedge clk); while (!frame_evt);
    endtask

    // count the cycles up to and including the next frame_evt; optional mid-frame duty write
    task automatic measure(output int len, output int hi, input int wr_at, input int wr_val);
        len = 0; hi = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            len++;
            hi += int'(pwm_out);
            if (len == wr_at) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = DATA_W'(wr_val);
            end
        end while (!frame_evt);
    endtask

    task automatic t_reset();
        int len, hi;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pwm in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        check("R1 irq after reset", int'(irq), 0);
        check("R1 pending after reset", int'(upd_pending), 0);
        check("R1 pwm at cnt0", int'(pwm_out), 0);
        measure(len, hi, -1, 0);
        check("R1 quiet frame high cycles", hi, 0);
        check("R2 reset frame length", len, RST_P);
        measure(len, hi, -1, 0);
        check("R4 cmp0 full frame", hi, RST_P + 1);
        check("R2 frame length", len, RST_P + 1);
    endtask

    task automatic t_duty();
        int len, hi;
        wr(2'd0, 8'd4);
        check("R8 pending after duty write", int'(upd_pending), 1);
        sync_frame();
        measure(len, hi, -1, 0);
        check("R3 cmp4 high cycles", hi, 12);
        wr(2'd0, 8'd15);
        sync_frame();
        measure(len, hi, -1, 0);
        check("R3 cmp equal period", hi, 1);
        wr(2'd0, 8'd200);
        sync_frame();
        measure(len, hi, -1, 0);
        check("R4 cmp above period", hi, 0);
    endtask

    task automatic t_pending();
        wr(2'd0, 8'd5);
        check("R8 pending set", int'(upd_pending), 1);
        sync_frame();
        @(negedge clk);
        check("R8 pending cleared at commit", int'(upd_pending), 0);
    endtask

    task automatic t_midframe();
        int len, hi;
        wr(2'd1, 8'd255);
        wr(2'd0, 8'd190);
        sync_frame();
        sync_frame();
        measure(len, hi, 150, 90);
        check("R5 frame keeps old compare", hi, 66);
        check("R2 full 8-bit frame", len, 256);
        measure(len, hi, -1, 0);
        check("R5 next frame uses new compare", hi, 166);
    endtask

    task automatic t_lastwins();
        int len, hi;
        wr(2'd1, 8'd15);
        sync_frame();
        wr(2'd0, 8'd3);
        wr(2'd0, 8'd9);
        sync_frame();
        measure(len, hi, -1, 0);
        check("R6 last duty write wins", hi, 7);
    endtask

    task automatic t_period();
        int len, hi;
        sync_frame();
        sync_frame();
        wr(2'd1, 8'd7);
        check("R8 boundary write keeps pending", int'(upd_pending), 1);
        measure(len, hi, -1, 0);
        check("R7 current frame keeps length", len, 15);
        measure(len, hi, -1, 0);
        check("R7 new period applied", len, 8);
        check("R3 cmp9 over period7", hi, 0);
    endtask

    task automatic t_irq();
        wr(2'd2, 8'd0);
        wr(2'd2, 8'd2);
        check("R9 irq off without enable", int'(irq), 0);
        sync_frame();
        @(negedge clk);
        check("R9 masked irq stays low", int'(irq), 0);
        wr(2'd2, 8'd1);
        check("R9 sticky flag seen once enabled", int'(irq), 1);
        @(negedge clk);
        check("R9 irq stays high", int'(irq), 1);
        wr(2'd2, 8'd3);
        check("R9 write-one clears flag", int'(irq), 0);
        sync_frame();
        @(negedge clk);
        check("R9 flag set at frame end", int'(irq), 1);
    endtask

    initial begin
        t_reset();
        t_duty();
        t_pending();
        t_midframe();
        t_lastwins();
        t_period();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule